// File: doc/BRIEF.md
# Cascadable Fall-Through Queue Chain

This block is a deep first-in, first-out queue built from a row of identical shallow stages. Each stage works in first-word-fall-through fashion. A stored word is presented on the stage output, and its active-low output-ready flag goes low, without any read request. Each stage's active-low input-ready flag is low while the stage has room for another word. Because both flags are active low, the stages join with no glue logic. A stage's output-ready drives the next stage's write enable, its data feeds the next stage's data input, and the next stage's input-ready drives its read enable.

All stages share one clock. A word written into an empty chain ripples down to the tail on its own. A word removed at the tail opens a free slot that bubbles back one stage at a time to the head. The usable depth is the sum of the stage depths. The ripple delay is seen only by a word that enters an empty chain. Once the stages hold data, words stream through at one per clock.

Top module: `fwft_chain`

## Requirements
- R1: While reset is held and on the first cycle after it is released, input-ready is low (0) and output-ready is high (1).
- R2: Words leave the tail in the order they were accepted at the head. While output-ready is low, the output data is the oldest word not yet read.
- R3: A single stage that is written while empty drives output-ready low after exactly 3 rising edges, counting the edge that accepts the write.
- R4: The first word written into an empty chain of NSTG stages reaches the tail after exactly 3×NSTG rising edges, counting the accepting edge, with no read issued.
- R5: The chain accepts exactly NSTG×DEPTH words before its input-ready goes high (1).
- R6: A write while input-ready is high is ignored. The word is neither stored nor delivered.
- R7: A read while output-ready is high is ignored. Output-ready stays high and the output data stays unchanged while no word is pending.
- R8: While output-ready is low and read enable is high, the output data and output-ready hold their values.
- R9: Once words are backed up in the chain, a read and a write on every clock keep output-ready low on every clock.
- R10: When one word is read from a full chain, the head's input-ready goes low after exactly NSTG rising edges, counting the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for every stage |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | W | Data written at the head |
| wr_n | input | 1 | Head write enable, active low |
| in_rdy_n | output | 1 | Low while the head stage can accept a word |
| dout | output | W | Word presented at the tail |
| rd_n | input | 1 | Tail read enable, active low |
| out_rdy_n | output | 1 | Low while dout holds a valid word |

## Verification
Some properties are checked on every cycle at every stage boundary. A stage never holds more than its depth. A stage whose input-ready is high never grows, and a stage whose output-ready is high never shrinks. An empty stage cannot raise output-ready on the very next edge. A held tail word stays put. The exact ripple and bubble latencies, the total capacity, the word order across mixed traffic, and streaming with no gaps can only be shown by the bench's scenarios, which count edges and compare the tail output with a reference queue.

// File: rtl/fwft_pkg.sv
// Package fwft_pkg
// Shared defaults and helpers for the fall-through chain.
// Assumes nothing beyond elaboration-time constant evaluation.
package fwft_pkg;
    localparam int DEF_W     = 18;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_NSTG  = 3;

    // Returns 1 when n is a positive power of two.
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction
endpackage

// File: rtl/fwft_store.sv
// Module fwft_store
// Word storage for one stage: a DEPTH-entry array with a write pointer and a
// read pointer. The read port is combinational at the read pointer.
// Assumes: the caller never writes to a full array or advances past the
// newest word. The stage's occupancy counter guarantees both.
module fwft_store #(
    parameter int W     = 18,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_adv,
    output logic [W-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW-1:0] wptr_nx, rptr_nx;

    // Pointer wrap: free-running for power-of-two depths, compare-and-clear otherwise.
    generate
        if (fwft_pkg::is_pow2(DEPTH)) begin : g_wrap_pow2
            assign wptr_nx = wptr + AW'(1);
            assign rptr_nx = rptr + AW'(1);
        end else begin : g_wrap_cmp
            assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
        end
    endgenerate

    // Array write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    // Pointer update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en)  wptr <= wptr_nx;
            if (rd_adv) rptr <= rptr_nx;
        end
    end

    assign rd_data = mem[rptr];
endmodule

// File: rtl/fwft_stage.sv
// Module fwft_stage
// One fall-through queue stage with active-low ready flags. A word accepted
// into an empty stage passes two pipeline slots and is then loaded into a
// registered output, so output-ready falls on the third edge. Both flags come
// straight from registers, so chained stages form no combinational path.
// Assumes: one write and one read at most per clock. occ counts every word
// held, including those in the delay slots and the output register.
module fwft_stage #(
    parameter int W     = 18,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [W-1:0]                 din,
    input  logic                         wr_n,
    output logic                         in_rdy_n,
    output logic [W-1:0]                 dout,
    input  logic                         rd_n,
    output logic                         out_rdy_n,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_fire, rd_fire, fetch, avail;
    logic          pend1, pend2;
    logic          ovld;
    logic [CW-1:0] occ_q, vis_q;
    logic [W-1:0]  dout_q, mem_rd;

    // Accept and consume qualifiers; requests against a full or empty stage drop.
    always_comb begin
        wr_fire = !wr_n && (occ_q < CW'(DEPTH));
        rd_fire = !rd_n && ovld;
        avail   = (vis_q != '0) || pend2;
        fetch   = avail && (!ovld || rd_fire);
    end

    fwft_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_data (din),
        .rd_adv  (fetch),
        .rd_data (mem_rd)
    );

    // Fixed delay slots that make a fresh word visible two edges after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend1 <= 1'b0;
            pend2 <= 1'b0;
        end else begin
            pend1 <= wr_fire;
            pend2 <= pend1;
        end
    end

    // Count of visible words still in the array, plus total occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
            occ_q <= '0;
        end else begin
            vis_q <= vis_q + CW'(pend2) - CW'(fetch);
            occ_q <= occ_q + CW'(wr_fire) - CW'(rd_fire);
        end
    end

    // Registered output word and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovld   <= 1'b0;
            dout_q <= '0;
        end else if (fetch) begin
            ovld   <= 1'b1;
            dout_q <= mem_rd;
        end else if (rd_fire) begin
            ovld   <= 1'b0;
        end
    end

    assign in_rdy_n  = (occ_q == CW'(DEPTH));
    assign out_rdy_n = !ovld;
    assign dout      = dout_q;
    assign occ       = occ_q;
endmodule

// File: rtl/fwft_chain.sv
// Module fwft_chain
// NSTG fall-through stages joined flag-to-enable. Each stage's output-ready
// is the next stage's write enable. Each downstream input-ready is the
// upstream read enable. Data ripples toward the tail and free slots bubble
// toward the head.
// Assumes: a single shared clock and synchronous active-low reset for all stages.
module fwft_chain #(
    parameter int W     = fwft_pkg::DEF_W,
    parameter int DEPTH = fwft_pkg::DEF_DEPTH,
    parameter int NSTG  = fwft_pkg::DEF_NSTG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         wr_n,
    output logic         in_rdy_n,
    output logic [W-1:0] dout,
    input  logic         rd_n,
    output logic         out_rdy_n
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NSTG-1:0][W-1:0]  st_din, st_dout;
    logic [NSTG-1:0]         st_wr_n, st_rd_n, st_ir_n, st_or_n;
    logic [NSTG-1:0][CW-1:0] st_occ;

    // Stage instances and their flag-to-enable links.
    generate
        for (genvar g = 0; g < NSTG; g++) begin : g_stage
            if (g == 0) begin : g_head
                assign st_din[g]  = din;
                assign st_wr_n[g] = wr_n;
            end else begin : g_link_in
                assign st_din[g]  = st_dout[g-1];
                assign st_wr_n[g] = st_or_n[g-1];
            end

            if (g == NSTG - 1) begin : g_tail
                assign st_rd_n[g] = rd_n;
            end else begin : g_link_out
                assign st_rd_n[g] = st_ir_n[g+1];
            end

            fwft_stage #(.W(W), .DEPTH(DEPTH)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .din       (st_din[g]),
                .wr_n      (st_wr_n[g]),
                .in_rdy_n  (st_ir_n[g]),
                .dout      (st_dout[g]),
                .rd_n      (st_rd_n[g]),
                .out_rdy_n (st_or_n[g]),
                .occ       (st_occ[g])
            );
        end
    endgenerate

    assign in_rdy_n  = st_ir_n[0];
    assign out_rdy_n = st_or_n[NSTG-1];
    assign dout      = st_dout[NSTG-1];
endmodule

// File: rtl/fwft_chain_chk.sv
// Module fwft_chain_chk
// Cycle-by-cycle properties of the chain and of each stage, bound to fwft_chain.
// Assumes: the occupancy bus carries each stage's held-word count.
module fwft_chain_chk #(
    parameter int W     = 18,
    parameter int DEPTH = 16,
    parameter int NSTG  = 3
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [W-1:0]                          dout,
    input logic                                  rd_n,
    input logic                                  out_rdy_n,
    input logic [NSTG-1:0]                       st_ir_n,
    input logic [NSTG-1:0]                       st_or_n,
    input logic [NSTG-1:0][$clog2(DEPTH+1)-1:0]  st_occ
);
    localparam int CW = $clog2(DEPTH + 1);

    // R8: a held tail word does not move or vanish.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy_n && rd_n) |=> (!out_rdy_n && $stable(dout)));

    generate
        for (genvar k = 0; k < NSTG; k++) begin : g_st
            // R5: no stage ever holds more than its depth.
            assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
                st_occ[k] <= CW'(DEPTH));

            // R6: a stage flagged full does not grow on the next edge.
            assert_full_no_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
                st_ir_n[k] |=> (st_occ[k] <= $past(st_occ[k])));

            // R7: a stage flagged empty at its output does not shrink.
            assert_empty_no_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
                st_or_n[k] |=> (st_occ[k] >= $past(st_occ[k])));

            // R3: an empty stage cannot present a word one edge later.
            assert_no_instant_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (st_occ[k] == '0) |=> st_or_n[k]);
        end
    endgenerate
endmodule

bind fwft_chain fwft_chain_chk #(.W(W), .DEPTH(DEPTH), .NSTG(NSTG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dout      (dout),
    .rd_n      (rd_n),
    .out_rdy_n (out_rdy_n),
    .st_ir_n   (st_ir_n),
    .st_or_n   (st_or_n),
    .st_occ    (st_occ)
);

// File: tb/fwft_chain_bench.sv
`timescale 1ns/1ps
// Bench for fwft_chain: a table of traffic phases checked against a reference
// queue, then directed latency, capacity, ignore and bubble tests.
module fwft_chain_bench;
    localparam int W     = 18;
    localparam int DEPTH = 16;
    localparam int NSTG  = 3;
    localparam int CAP   = NSTG * DEPTH;

    // Each entry: {cycles[7:0], write, read}
    localparam logic [9:0] VEC [9] = '{
        {8'd5,  2'b10}, {8'd20, 2'b11}, {8'd4,  2'b01},
        {8'd30, 2'b10}, {8'd12, 2'b11}, {8'd70, 2'b01},
        {8'd6,  2'b01}, {8'd40, 2'b11}, {8'd90, 2'b01}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] din, dout, s_din, s_dout;
    logic wr_n, rd_n, in_rdy_n, out_rdy_n;
    logic s_wr_n, s_rd_n, s_in_rdy_n, s_out_rdy_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int pops   = 0;
    logic [W-1:0] wdata = 18'd1;
    logic [W-1:0] q [$];

    always #2.5 clk = ~clk;

    fwft_chain #(.W(W), .DEPTH(DEPTH), .NSTG(NSTG)) u_fwft_chain (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .in_rdy_n(in_rdy_n),
        .dout(dout), .rd_n(rd_n), .out_rdy_n(out_rdy_n)
    );

    fwft_chain #(.W(W), .DEPTH(DEPTH), .NSTG(1)) u_single (
        .clk(clk), .rst_n(rst_n), .din(s_din), .wr_n(s_wr_n), .in_rdy_n(s_in_rdy_n),
        .dout(s_dout), .rd_n(s_rd_n), .out_rdy_n(s_out_rdy_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock of traffic at the main instance; called and returns at a falling edge.
    task automatic step(input logic w, input logic r);
        wr_n = !w;
        rd_n = !r;
        din  = wdata;
        if (r && !out_rdy_n) begin
            if (q.size() == 0) chk("R2", "unexpected word", 32'(dout), 32'h0);
            else begin
                chk("R2", "word order", 32'(dout), 32'(q[0]));
                void'(q.pop_front());
            end
            pops++;
        end
        if (w && !in_rdy_n) begin
            q.push_back(wdata);
            wdata = wdata + 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R2): actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lat;
        int drops;
        logic [W-1:0] held;
        rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; din = '0;
        s_wr_n = 1'b1; s_rd_n = 1'b1; s_din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of both instances
        chk("R1", "in_rdy_n", 32'(in_rdy_n), 32'h0);
        chk("R1", "out_rdy_n", 32'(out_rdy_n), 32'h1);
        chk("R1", "single in_rdy_n", 32'(s_in_rdy_n), 32'h0);
        chk("R1", "single out_rdy_n", 32'(s_out_rdy_n), 32'h1);

        // R3: single-stage fall-through latency
        s_wr_n = 1'b0; s_din = 18'h00155;
        @(posedge clk); @(negedge clk);
        s_wr_n = 1'b1;
        lat = 1;
        while (s_out_rdy_n && lat < 40) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        chk("R3", "stage latency", 32'(lat), 32'd3);
        chk("R3", "stage word", 32'(s_dout), 32'h155);

        // R4: first word into an empty chain
        step(1'b1, 1'b0);
        lat = 1;
        while (out_rdy_n && lat < 60) begin
            step(1'b0, 1'b0);
            lat++;
        end
        chk("R4", "chain latency", 32'(lat), 32'(3 * NSTG));
        chk("R4", "tail word", 32'(dout), 32'(q[0]));

        // R8: word held while no read
        held = dout;
        repeat (5) step(1'b0, 1'b0);
        chk("R8", "held word", 32'(dout), 32'(held));
        chk("R8", "held flag", 32'(out_rdy_n), 32'h0);

        // R9: back up words, then read and write every clock
        repeat (10) step(1'b1, 1'b0);
        repeat (20) step(1'b0, 1'b0);
        drops = 0;
        for (int i = 0; i < 30; i++) begin
            if (out_rdy_n) drops++;
            step(1'b1, 1'b1);
        end
        chk("R9", "stream gaps", 32'(drops), 32'd0);

        repeat (70) step(1'b0, 1'b1);
        chk("R2", "drained model", 32'(q.size()), 32'd0);
        chk("R2", "drained flag", 32'(out_rdy_n), 32'h1);

        // R7: reads against an empty chain
        held = dout;
        drops = 0;
        for (int i = 0; i < 5; i++) begin
            if (!out_rdy_n) drops++;
            step(1'b0, 1'b1);
        end
        chk("R7", "flag stayed high", 32'(drops), 32'd0);
        chk("R7", "output unchanged", 32'(dout), 32'(held));

        // R2: table of traffic phases
        for (int i = 0; i < 9; i++) begin
            for (int c = 0; c < int'(VEC[i][9:2]); c++) step(VEC[i][1], VEC[i][0]);
        end
        chk("R2", "table drained", 32'(q.size()), 32'd0);

        // R5: capacity
        repeat (150) step(1'b1, 1'b0);
        chk("R5", "accepted words", 32'(q.size()), 32'(CAP));
        chk("R5", "full flag", 32'(in_rdy_n), 32'h1);

        // R10: bubble of one free slot back to the head
        step(1'b0, 1'b1);
        lat = 1;
        while (in_rdy_n && lat < 60) begin
            step(1'b0, 1'b0);
            lat++;
        end
        chk("R10", "bubble latency", 32'(lat), 32'(NSTG));
        repeat (10) step(1'b1, 1'b0);
        chk("R5", "refilled", 32'(q.size()), 32'(CAP));

        // R6: writes against a full chain are dropped
        drops = 0;
        for (int i = 0; i < 10; i++) begin
            wr_n = 1'b0; rd_n = 1'b1; din = 18'h2BAD5;
            if (!in_rdy_n) drops++;
            @(posedge clk); @(negedge clk);
        end
        wr_n = 1'b1;
        chk("R6", "flag stayed high", 32'(drops), 32'd0);
        pops = 0;
        repeat (160) step(1'b0, 1'b1);
        chk("R6", "words delivered", 32'(pops), 32'(CAP));
        chk("R6", "nothing extra", 32'(out_rdy_n), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule